// File: doc/BRIEF.md
# Triple-Redundant Sequential Fixed-Width Multiplier

This block multiplies two unsigned N-bit operands and returns the low N bits of the product. It does not lay out the full partial-product array. A single processing element adds four partial-product rows to a running accumulator in each cycle, so one operation takes N/4 cycles. The element is built three times and fed identical inputs. At the end of every stage a bitwise two-of-three vote picks the value that is written into the one shared accumulator. A fault confined to one copy is therefore masked. Any disagreement between a copy and the vote sets a sticky flag.

Operands enter through a valid/ready handshake. An operation is accepted on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low for the whole computation, and `in_valid` has no effect while it is low. The producer must hold its operands until an accepting edge. The result side has no back-pressure. `done` pulses for one cycle, and `prod` then holds its value until the next operation is accepted. Per-copy fault-injection pins let a test invert one chosen bit of any copy's stage result.

Top module: `tmr_mult`

## Requirements
- R1: After reset, `in_ready` is 1, and `done`, `mismatch` and `prod` are all 0.
- R2: Without injected faults, `prod` at `done` equals (a*b) mod 2^N for the accepted unsigned operands, including zero and all-ones operands.
- R3: A transfer occurs on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until `done`. `in_valid` and the operands are ignored while `in_ready` is 0. `in_ready` is 1 during the `done` cycle.
- R4: `done` rises exactly N/4 clock cycles after the accepting edge and is high for exactly one cycle.
- R5: After `done`, `prod` keeps its value until the next transfer is accepted.
- R6: Setting `flt_en[i]` inverts bit `flt_pos` of copy i's result in every stage. With one bit of `flt_en` set, `prod` is still (a*b) mod 2^N and `mismatch` is 1 at `done`.
- R7: With `flt_en` all zero, `mismatch` is 0 at `done`.
- R8: `mismatch` is sticky until the next accepted transfer, which clears it.
- R9: With two copies faulted at the same `flt_pos`, the vote follows the faulted pair. Each stage's stored value is then the correct stage sum with bit `flt_pos` inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can accept operands |
| in_a | input | N | Multiplicand |
| in_b | input | N | Multiplier |
| flt_en | input | 3 | Per-copy fault-injection enable |
| flt_pos | input | $clog2(N) | Bit inverted in each enabled copy |
| done | output | 1 | One-cycle result strobe |
| prod | output | N | Low N bits of the product |
| mismatch | output | 1 | A copy was outvoted during the operation |

## Verification
The bench targets all-ones operands, where carries ripple past bit N-1. An accumulator that drops the carry or mis-truncates would give a wrong low half. It also offers new operands in the middle of a run; a block that latched them would return their product or shorten the latency. Each copy is faulted in turn, and a voter that trusted one fixed copy would return a corrupted product. A double fault must follow the bit-flipped stage model, which exposes a voter that is not a true majority or that votes only once at the end. Mismatch is checked after an idle gap and again after a clean operation, to catch a flag that is not sticky or is never cleared.

// File: rtl/tmr_mult_pkg.sv
package tmr_mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_e;

  function automatic int stage_count(input int width);
    return width / 4;
  endfunction
endpackage

// File: rtl/tmr_csa42.sv
// Vector 4:2 compressor built from two carry-save layers; the carries are
// re-aligned by one bit and truncated to W bits.
module tmr_csa42 #(
  parameter int W = 16
) (
  input  logic [W-1:0] x0,
  input  logic [W-1:0] x1,
  input  logic [W-1:0] x2,
  input  logic [W-1:0] x3,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] s1, c1, cin, c2;

  assign s1    = x0 ^ x1 ^ x2;
  assign c1    = (x0 & x1) | (x1 & x2) | (x0 & x2);
  assign cin   = {c1[W-2:0], 1'b0};
  assign sum   = s1 ^ x3 ^ cin;
  assign c2    = (s1 & x3) | (x3 & cin) | (s1 & cin);
  assign carry = {c2[W-2:0], 1'b0};
endmodule

// File: rtl/tmr_pe.sv
// One processing element: accumulator plus four shifted partial-product rows.
module tmr_pe #(
  parameter int N   = 64,
  parameter int STW = 4
) (
  input  logic [N-1:0]   acc,
  input  logic [N-1:0]   a,
  input  logic [3:0]     b_grp,
  input  logic [STW-1:0] step,
  output logic [N-1:0]   nxt
);
  localparam int SHW = STW + 2;

  logic [N-1:0]   row [4];
  logic [SHW-1:0] base;
  logic [N-1:0]   cs_s, cs_c, s2, c2m, c2;

  assign base = {step, 2'b00};

  for (genvar k = 0; k < 4; k++) begin : g_row
    logic [SHW-1:0] sh;
    assign sh     = base + SHW'(k);
    assign row[k] = b_grp[k] ? (a << sh) : '0;
  end

  tmr_csa42 #(.W(N)) i_csa (
    .x0   (row[0]),
    .x1   (row[1]),
    .x2   (row[2]),
    .x3   (row[3]),
    .sum  (cs_s),
    .carry(cs_c)
  );

  assign s2  = acc ^ cs_s ^ cs_c;
  assign c2m = (acc & cs_s) | (cs_s & cs_c) | (acc & cs_c);
  assign c2  = {c2m[N-2:0], 1'b0};
  assign nxt = s2 + c2;
endmodule

// File: rtl/tmr_vote.sv
// Bitwise two-of-three vote with a disagreement indication.
module tmr_vote #(
  parameter int N = 64
) (
  input  logic [N-1:0] r0,
  input  logic [N-1:0] r1,
  input  logic [N-1:0] r2,
  output logic [N-1:0] voted,
  output logic         disagree
);
  assign voted    = (r0 & r1) | (r1 & r2) | (r0 & r2);
  assign disagree = |((r0 ^ voted) | (r1 ^ voted) | (r2 ^ voted));
endmodule

// File: rtl/tmr_ctl.sv
// Sequencer: IDLE -> RUN for N/4 stages -> DONE for one cycle.
module tmr_ctl #(
  parameter int STEPS = 16,
  parameter int STW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  output logic           load,
  output logic           run_en,
  output logic           done,
  output logic [STW-1:0] step
);
  import tmr_mult_pkg::*;

  localparam logic [STW-1:0] LAST = STW'(STEPS - 1);

  ctl_state_e state;

  assign in_ready = (state != ST_RUN);
  assign load     = in_valid && in_ready;
  assign run_en   = (state == ST_RUN);
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (step == LAST) begin
            state <= ST_DONE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: begin
          if (load) begin
            state <= ST_RUN;
            step  <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_mult.sv
module tmr_mult #(
  parameter int N = 64,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N-1:0]  in_a,
  input  logic [N-1:0]  in_b,
  input  logic [2:0]    flt_en,
  input  logic [PW-1:0] flt_pos,
  output logic          done,
  output logic [N-1:0]  prod,
  output logic          mismatch
);
  localparam int STEPS = tmr_mult_pkg::stage_count(N);
  localparam int STW   = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic           load, run_en, disagree;
  logic [STW-1:0] step;
  logic [N-1:0]   a_q, b_q, acc_q, voted;
  logic [3:0]     b_grp;
  logic [N-1:0]   pe_raw [3];
  logic [N-1:0]   pe_out [3];

  initial begin
    if (N % 4 != 0 || N < 8) $error("tmr_mult: N must be a multiple of 4, at least 8");
  end

  tmr_ctl #(.STEPS(STEPS), .STW(STW)) i_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .load    (load),
    .run_en  (run_en),
    .done    (done),
    .step    (step)
  );

  assign b_grp = b_q[{step, 2'b00} +: 4];

  for (genvar i = 0; i < 3; i++) begin : g_copy
    tmr_pe #(.N(N), .STW(STW)) i_pe (
      .acc  (acc_q),
      .a    (a_q),
      .b_grp(b_grp),
      .step (step),
      .nxt  (pe_raw[i])
    );
    assign pe_out[i] = flt_en[i] ? (pe_raw[i] ^ (N'(1) << flt_pos)) : pe_raw[i];
  end

  tmr_vote #(.N(N)) i_vote (
    .r0      (pe_out[0]),
    .r1      (pe_out[1]),
    .r2      (pe_out[2]),
    .voted   (voted),
    .disagree(disagree)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      acc_q    <= '0;
      mismatch <= 1'b0;
    end else if (load) begin
      a_q      <= in_a;
      b_q      <= in_b;
      acc_q    <= '0;
      mismatch <= 1'b0;
    end else if (run_en) begin
      acc_q <= voted;
      if (disagree) mismatch <= 1'b1;
    end
  end

  assign prod = acc_q;
endmodule

// File: rtl/tmr_mult_chk.sv
module tmr_mult_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         done,
  input logic         mismatch,
  input logic [N-1:0] prod
);
  localparam int STEPS = N / 4;

  int cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else if (in_valid && in_ready) cyc <= 0;
    else if (!in_ready) cyc <= cyc + 1;
  end

  assert_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc == STEPS));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(prod));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !mismatch);
endmodule

bind tmr_mult tmr_mult_chk #(.N(N)) i_tmr_mult_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .done    (done),
  .mismatch(mismatch),
  .prod    (prod)
);

// File: tb/test_tmr_mult.sv
`timescale 1ns/1ps
module test_tmr_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        v16 = 1'b0, r16, d16, m16;
  logic [15:0] a16 = '0, b16 = '0, p16;
  logic [2:0]  fe16 = '0;
  logic [3:0]  fp16 = '0;
  logic        v8 = 1'b0, r8, d8, m8;
  logic [7:0]  a8 = '0, b8 = '0, p8;
  logic [2:0]  fe8 = '0;
  logic [2:0]  fp8 = '0;

  int n_run = 0;
  int n_fail = 0;

  tmr_mult #(.N(16)) i_tmr_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_ready(r16),
    .in_a(a16), .in_b(b16), .flt_en(fe16), .flt_pos(fp16),
    .done(d16), .prod(p16), .mismatch(m16)
  );

  tmr_mult #(.N(8)) i_tmr_mult_n8 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_ready(r8),
    .in_a(a8), .in_b(b8), .flt_en(fe8), .flt_pos(fp8),
    .done(d8), .prod(p8), .mismatch(m8)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Stage-by-stage reference: flip is XORed into every stored stage value.
  function automatic logic [15:0] model(input bit w8, input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] flip);
    int n = w8 ? 8 : 16;
    logic [15:0] m = w8 ? 16'h00ff : 16'hffff;
    logic [15:0] acc = '0;
    for (int s = 0; s < n / 4; s++) begin
      for (int k = 0; k < 4; k++)
        if (b[4*s+k]) acc = acc + (a << (4*s + k));
      acc = (acc ^ flip) & m;
    end
    return acc & m;
  endfunction

  task automatic do_op(input bit w8, input logic [15:0] a, input logic [15:0] b,
                       input logic [2:0] fen, input logic [3:0] fpos,
                       output logic [15:0] p, output logic mm, output int lat);
    @(negedge clk);
    if (w8) begin a8 = a[7:0]; b8 = b[7:0]; fe8 = fen; fp8 = fpos[2:0]; v8 = 1'b1; end
    else    begin a16 = a;     b16 = b;     fe16 = fen; fp16 = fpos;    v16 = 1'b1; end
    @(negedge clk);
    v8 = 1'b0; v16 = 1'b0;
    lat = 0;
    while (!(w8 ? d8 : d16) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    p  = w8 ? {8'h00, p8} : p16;
    mm = w8 ? m8 : m16;
    fe8 = '0; fe16 = '0;
  endtask

  task automatic t_reset;
    chk("R1 in_ready16", r16, 1); chk("R1 done16", d16, 0);
    chk("R1 mismatch16", m16, 0); chk("R1 prod16", p16, 0);
    chk("R1 in_ready8", r8, 1);   chk("R1 prod8", p8, 0);
  endtask

  task automatic t_corners;
    logic [15:0] p; logic mm; int lat;
    do_op(0, 16'hffff, 16'hffff, 3'b000, 0, p, mm, lat);
    chk("R2 ones16", p, 16'h0001); chk("R4 latency16", lat, 4);
    @(negedge clk); chk("R4 done one cycle", d16, 0);
    do_op(1, 16'h00ff, 16'h00ff, 3'b000, 0, p, mm, lat);
    chk("R2 ones8", p, 16'h0001); chk("R4 latency8", lat, 2);
    do_op(0, 16'h0000, 16'hbeef, 3'b000, 0, p, mm, lat);
    chk("R2 zero16", p, 0);
    do_op(1, 16'h005a, 16'h0000, 3'b000, 0, p, mm, lat);
    chk("R2 zero8", p, 0);
  endtask

  task automatic t_random;
    logic [15:0] p; logic mm; int lat;
    for (int i = 0; i < 24; i++) begin
      bit w8 = i[0];
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      if (w8) begin a[15:8] = '0; b[15:8] = '0; end
      do_op(w8, a, b, 3'b000, 0, p, mm, lat);
      chk("R2 random", p, w8 ? 16'((a * b) & 16'h00ff) : 16'(a * b));
      chk("R7 no mismatch", mm, 0);
    end
  endtask

  task automatic t_busy;
    int lat = 0;
    @(negedge clk); a16 = 16'h1234; b16 = 16'h0107; v16 = 1'b1;
    @(negedge clk); a16 = 16'hffff; b16 = 16'hffff;
    chk("R3 busy not ready", r16, 0);
    while (!d16 && lat < 100) begin @(negedge clk); lat++; end
    v16 = 1'b0;
    chk("R3 ignored operands", p16, 16'(16'h1234 * 16'h0107));
    chk("R3 latency unaffected", lat, 4);
    chk("R3 ready at done", r16, 1);
  endtask

  task automatic t_hold;
    logic [15:0] p; logic mm; int lat;
    do_op(0, 16'h0f0f, 16'h3003, 3'b000, 0, p, mm, lat);
    repeat (4) @(negedge clk);
    chk("R5 hold", p16, p);
  endtask

  task automatic t_single;
    logic [15:0] p; logic mm; int lat;
    for (int i = 0; i < 3; i++) begin
      do_op(0, 16'hab37, 16'h9c41, 3'(1 << i), 4'(3 + 4 * i), p, mm, lat);
      chk("R6 single fault product", p, 16'(16'hab37 * 16'h9c41));
      chk("R6 mismatch set", mm, 1);
    end
    do_op(1, 16'h00e5, 16'h00d3, 3'b010, 4'd7, p, mm, lat);
    chk("R6 single fault product8", p, 16'((16'h00e5 * 16'h00d3) & 16'h00ff));
  endtask

  task automatic t_sticky;
    logic [15:0] p; logic mm; int lat;
    do_op(0, 16'h0101, 16'h0202, 3'b100, 4'd1, p, mm, lat);
    repeat (3) @(negedge clk);
    chk("R8 sticky while idle", m16, 1);
    do_op(0, 16'h0101, 16'h0202, 3'b000, 0, p, mm, lat);
    chk("R8 cleared by next op", mm, 0);
  endtask

  task automatic t_double;
    logic [15:0] p; logic mm; int lat;
    do_op(0, 16'h4d21, 16'h7e5b, 3'b011, 4'd9, p, mm, lat);
    chk("R9 double fault follows pair", p, model(0, 16'h4d21, 16'h7e5b, 16'h0200));
    do_op(1, 16'h0033, 16'h0077, 3'b110, 4'd0, p, mm, lat);
    chk("R9 double fault n8", p, model(1, 16'h0033, 16'h0077, 16'h0001));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_corners;
    t_random;
    t_busy;
    t_hold;
    t_single;
    t_sticky;
    t_double;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule